// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers the interrupt requests of a small processor subsystem and turns them into one serviced request with a vector index. Fifteen maskable sources are handled. Fourteen of them arrive as single-cycle event strobes from peripherals. The fifteenth is an external active-low request pin. A separate group of nonmaskable sources is handled as well: several level requests from elsewhere in the chip, plus an external active-low nonmaskable pin.

Each strobed source latches a pending flag. Software clears a flag by writing a one to its position. A flag only takes part in arbitration when its enable bit is also set. A fixed priority ranking decides among the recognized sources, and a select field can lift any one source above all the others. The CPU's global maskable-disable bit holds back maskable service. Nonmaskable requests always win and are never held back by that bit.

The external maskable pin has no enable bit. It is either falling-edge latched or level-following, and the mode bit that chooses between them can only be changed for a short time after reset. The external nonmaskable pin is level-sensitive. It stays inert until the CPU's X bit has been seen clear once after reset. The CPU's stacking, vector fetch and return sequence belong to the CPU.

Top module: `irqc_top`

## Requirements
- R1: A strobe on `evt_i[k-1]` sets the flag of source k (k = 1..14) in the next cycle, whatever its enable bit. The flag then reads as 1 at bit k of register 0.
- R2: A write to register 0 clears every flag whose bit in `wdata_i` is 1 and leaves the others unchanged. Bit 0 clears the latched external request. Software can never set a flag.
- R3: Source k is recognized only when its flag and its enable bit (register 1, bit k) are both 1. `irq_o` is 1 only when a maskable source is recognized, no nonmaskable request is pending, and `i_bit_i` was 0 in the previous cycle. Outputs are registered, one cycle behind the state they reflect.
- R4: The default ranking, highest first, is source index 0 to 14. That is: external pin, periodic timer, capture 1 to 3, compare 1 to 4, capture 4/compare 5, timer overflow, pulse-counter overflow, pulse-counter edge, SPI, SCI. `vec_o` carries the winning index.
- R5: Register 3 bits [3:0] hold a source index that ranks above all others whenever that source is recognized. Its reset value is 0. The value 15 selects no source.
- R6: In edge mode (register 2 bit 0 = 1, the reset value), a falling edge on `irq_n_i` latches source 0 pending. It stays pending after the pin rises, until cleared through register 0 bit 0.
- R7: In level mode (register 2 bit 0 = 0), source 0 is pending exactly while the synchronized pin is low, with no latch.
- R8: Writes to register 2 take effect only during the first 64 cycles after reset. Later writes are ignored.
- R9: `xirq_n_i` low raises a nonmaskable request only after `x_bit_i` has been 0 in some cycle since reset. That enable stays set until the next reset.
- R10: A nonmaskable request sets `nmi_o`, forces `irq_o` to 0 and is not blocked by `i_bit_i`. `nm_src_i[k]` gives vector 15+k and the external nonmaskable pin gives vector 19. A lower vector ranks higher.
- R11: After reset `irq_o`, `nmi_o` and `vec_o` are 0, all flags and enables are 0, register 2 reads 1 and register 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 14 | Event strobes of maskable sources 1..14 (bit k-1 for source k) |
| nm_src_i | input | 4 | Internal nonmaskable level requests |
| irq_n_i | input | 1 | External maskable request pin, active low |
| xirq_n_i | input | 1 | External nonmaskable request pin, active low |
| i_bit_i | input | 1 | CPU global maskable-disable bit |
| x_bit_i | input | 1 | CPU nonmaskable-pin disable bit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 flags, 1 enables, 2 option, 3 priority select |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Read data of the addressed register |
| irq_o | output | 1 | Maskable service request |
| nmi_o | output | 1 | Nonmaskable request |
| vec_o | output | 5 | Index of the winning request |

## Verification
The hardest situation to reach is the mode change of the external pin. The mode bit only accepts writes for 64 cycles after reset, and by the time the main sequence has run, that window is long closed. The bench therefore first shows that a late write to register 2 is ignored. It then applies a second reset and writes level mode straight away, so that the level-following behaviour can be shown. The same second reset shows that the nonmaskable pin has gone inert again.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the interrupt request controller.
// Assumes one clock domain; external pins are asynchronous.
package irqc_pkg;
    localparam int NSRC = 15;                      // maskable sources
    localparam int NNM  = 4;                       // internal nonmaskable sources
    localparam int DW   = 16;                      // register data width
    localparam int AW   = 2;                       // register address width
    localparam int WIN  = 64;                      // option write window, cycles
    localparam int IW   = $clog2(NSRC);            // maskable index width
    localparam int NW   = $clog2(NNM + 1);         // nonmaskable index width
    localparam int VW   = $clog2(NSRC + NNM + 1);  // vector width
    localparam logic [AW-1:0] A_FLAG = 2'd0;
    localparam logic [AW-1:0] A_MASK = 2'd1;
    localparam logic [AW-1:0] A_OPT  = 2'd2;
    localparam logic [AW-1:0] A_PSEL = 2'd3;
endpackage

// File: rtl/irqc_pin.sv
// Module: external maskable request pin handling.
// Synchronizes the active-low pin and detects falling edges. It keeps the
// edge/level mode bit, which is writable only in a window after reset.
// Assumes the pin idles high.
module irqc_pin #(
    parameter int WIN = irqc_pkg::WIN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n_i,
    input  logic opt_wr_i,
    input  logic opt_bit_i,
    input  logic clr_i,
    output logic pend_o,
    output logic edge_en_o
);
    localparam int CW = $clog2(WIN + 1);

    logic          s1, s2, prev;
    logic          latch_q;
    logic [CW-1:0] win_cnt;
    logic          win_open;

    assign win_open = (win_cnt < CW'(WIN));

    // two-flop synchronizer plus previous-value flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            prev <= 1'b1;
        end else begin
            s1   <= irq_n_i;
            s2   <= s1;
            prev <= s2;
        end
    end

    // counts cycles since reset until the option window closes
    always_ff @(posedge clk) begin
        if (!rst_n)        win_cnt <= '0;
        else if (win_open) win_cnt <= win_cnt + 1'b1;
    end

    // mode bit, writable only while the window is open
    always_ff @(posedge clk) begin
        if (!rst_n)                    edge_en_o <= 1'b1;
        else if (opt_wr_i && win_open) edge_en_o <= opt_bit_i;
    end

    // latched request in edge mode; a new edge wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)                          latch_q <= 1'b0;
        else if (edge_en_o && prev && !s2)   latch_q <= 1'b1;
        else if (clr_i || !edge_en_o)        latch_q <= 1'b0;
    end

    // pending state: latch in edge mode, pin level in level mode
    always_comb pend_o = edge_en_o ? latch_q : !s2;

    AST_OPT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !win_open && !$past(win_open)) |-> $stable(edge_en_o)); // R8

    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && edge_en_o && $past(edge_en_o) && $past(pend_o) && !$past(clr_i))
        |-> pend_o); // R6
endmodule

// File: rtl/irqc_flags.sv
// Module: pending flags and enable bits of the strobed maskable sources.
// Flags set on a strobe and clear on a write of one. A strobe wins over a
// same-cycle clear. Produces the recognized vector (flag AND enable).
module irqc_flags #(
    parameter int N = irqc_pkg::NSRC - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    input  logic         mask_wr_i,
    input  logic [N-1:0] mask_d_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] rec_o
);
    // flag update: set by event, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= '0;
        else        flag_o <= (flag_o & ~clr_i) | evt_i;
    end

    // enable bits, plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_o <= '0;
        else if (mask_wr_i) mask_o <= mask_d_i;
    end

    // recognition gate
    always_comb rec_o = flag_o & mask_o;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(evt_i) & ~flag_o) == '0)); // R1

    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flag_o & ~$past(flag_o) & ~$past(evt_i)) == '0)); // R2
endmodule

// File: rtl/irqc_arb.sv
// Module: combinational arbiters.
// The maskable arbiter ranks lowest index first and lifts one selected index
// above all others. The nonmaskable arbiter ranks lowest index first.
module irqc_arb #(
    parameter int NSRC = irqc_pkg::NSRC,
    parameter int NNM  = irqc_pkg::NNM,
    parameter int IW   = irqc_pkg::IW,
    parameter int NW   = irqc_pkg::NW
) (
    input  logic [NSRC-1:0] rec_i,
    input  logic [IW-1:0]   psel_i,
    input  logic [NNM:0]    nm_i,
    output logic            m_any_o,
    output logic [IW-1:0]   m_idx_o,
    output logic            n_any_o,
    output logic [NW-1:0]   n_idx_o
);
    // maskable winner with optional promotion
    always_comb begin
        m_any_o = 1'b0;
        m_idx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (rec_i[i]) begin
                m_any_o = 1'b1;
                m_idx_o = IW'(i);
            end
        end
        for (int i = 0; i < NSRC; i++) begin
            if (psel_i == IW'(i) && rec_i[i]) m_idx_o = IW'(i);
        end
    end

    // nonmaskable winner
    always_comb begin
        n_any_o = 1'b0;
        n_idx_o = '0;
        for (int i = NNM; i >= 0; i--) begin
            if (nm_i[i]) begin
                n_any_o = 1'b1;
                n_idx_o = NW'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
// Module: interrupt request controller top.
// Decodes the register bus, keeps the priority select and the sticky
// nonmaskable-pin enable, synchronizes the nonmaskable pin and registers the
// request outputs. Assumes the CPU mask bits are synchronous to clk.
module irqc_top
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-2:0] evt_i,
    input  logic [NNM-1:0]  nm_src_i,
    input  logic            irq_n_i,
    input  logic            xirq_n_i,
    input  logic            i_bit_i,
    input  logic            x_bit_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    output logic            irq_o,
    output logic            nmi_o,
    output logic [VW-1:0]   vec_o
);
    logic            irq_pend, edge_en;
    logic [NSRC-2:0] flag, mask, rec_s;
    logic [IW-1:0]   psel;
    logic            x_en, xs1, xs2;
    logic            m_any, n_any;
    logic [IW-1:0]   m_idx;
    logic [NW-1:0]   n_idx;
    logic            wr_flag, wr_mask, wr_opt, wr_psel;

    // register write decode
    always_comb begin
        wr_flag = wr_en_i && (addr_i == A_FLAG);
        wr_mask = wr_en_i && (addr_i == A_MASK);
        wr_opt  = wr_en_i && (addr_i == A_OPT);
        wr_psel = wr_en_i && (addr_i == A_PSEL);
    end

    irqc_pin #(.WIN(WIN)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_n_i   (irq_n_i),
        .opt_wr_i  (wr_opt),
        .opt_bit_i (wdata_i[0]),
        .clr_i     (wr_flag && wdata_i[0]),
        .pend_o    (irq_pend),
        .edge_en_o (edge_en)
    );

    irqc_flags #(.N(NSRC - 1)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .clr_i     (wr_flag ? wdata_i[NSRC-1:1] : '0),
        .mask_wr_i (wr_mask),
        .mask_d_i  (wdata_i[NSRC-1:1]),
        .flag_o    (flag),
        .mask_o    (mask),
        .rec_o     (rec_s)
    );

    irqc_arb #(.NSRC(NSRC), .NNM(NNM), .IW(IW), .NW(NW)) u_arb (
        .rec_i   ({rec_s, irq_pend}),
        .psel_i  (psel),
        .nm_i    ({x_en && !xs2, nm_src_i}),
        .m_any_o (m_any),
        .m_idx_o (m_idx),
        .n_any_o (n_any),
        .n_idx_o (n_idx)
    );

    // priority select register
    always_ff @(posedge clk) begin
        if (!rst_n)       psel <= '0;
        else if (wr_psel) psel <= wdata_i[IW-1:0];
    end

    // nonmaskable pin synchronizer and sticky enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xs1  <= 1'b1;
            xs2  <= 1'b1;
            x_en <= 1'b0;
        end else begin
            xs1  <= xirq_n_i;
            xs2  <= xs1;
            if (!x_bit_i) x_en <= 1'b1;
        end
    end

    // registered request outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            nmi_o <= 1'b0;
            vec_o <= '0;
        end else begin
            nmi_o <= n_any;
            irq_o <= !n_any && m_any && !i_bit_i;
            if (n_any)      vec_o <= VW'(NSRC) + VW'(n_idx);
            else if (m_any) vec_o <= VW'(m_idx);
            else            vec_o <= '0;
        end
    end

    // register read mux
    always_comb begin
        unique case (addr_i)
            A_FLAG:  rdata_o = DW'({flag, irq_pend});
            A_MASK:  rdata_o = DW'({mask, 1'b0});
            A_OPT:   rdata_o = DW'(edge_en);
            default: rdata_o = DW'(psel);
        endcase
    end

    AST_I_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(i_bit_i) |-> !irq_o); // R3

    AST_NMI_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> (!irq_o && vec_o >= VW'(NSRC))); // R10

    AST_XEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(x_en)) |-> x_en); // R9
endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] evt_i = '0;
    logic [3:0]  nm_src_i = '0;
    logic        irq_n_i = 1'b1, xirq_n_i = 1'b1;
    logic        i_bit_i = 1'b0, x_bit_i = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        irq_o, nmi_o;
    logic [4:0]  vec_o;

    int n_run = 0, n_fail = 0;

    typedef struct {
        logic       irq;
        logic       nmi;
        logic [4:0] vec;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    irqc_top uut (.*);

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (irq_o !== e.irq || nmi_o !== e.nmi || vec_o !== e.vec) begin
                n_fail++;
                $display("FAIL %s: got irq=%0b nmi=%0b vec=%0d, exp irq=%0b nmi=%0b vec=%0d",
                         e.tag, irq_o, nmi_o, vec_o, e.irq, e.nmi, e.vec);
            end
        end
    end

    // driver side: let inputs settle, push expectation, wait for its check
    task automatic expect_out(input logic i, input logic n, input logic [4:0] v, input string tag);
        exp_t e;
        repeat (6) @(negedge clk);
        @(posedge clk);
        #1;
        e.irq = i; e.nmi = n; e.vec = v; e.tag = tag;
        sb.push_back(e);
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic chk_reg(input logic [1:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        addr_i = a;
        #1;
        n_run++;
        if (rdata_o !== exp) begin
            n_fail++;
            $display("FAIL %s: reg%0d got %h exp %h", tag, a, rdata_o, exp);
        end
    endtask

    task automatic pulse(input logic [13:0] m);
        @(negedge clk);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R11: reset state
        expect_out(0, 0, 0, "R11 outputs");
        chk_reg(0, 16'h0000, "R11 flags");
        chk_reg(1, 16'h0000, "R11 enables");
        chk_reg(2, 16'h0001, "R11 option");
        chk_reg(3, 16'h0000, "R11 psel");
        // R1: flag sets with enable off; R3: no request without enable
        pulse(14'b1 << 4);                       // source 5
        chk_reg(0, 16'h0020, "R1 flag5");
        expect_out(0, 0, 0, "R3 masked");
        wr(1, 16'h0020);
        expect_out(1, 0, 5, "R3 enabled");
        @(negedge clk) i_bit_i = 1'b1;
        expect_out(0, 0, 5, "R3 I bit");
        @(negedge clk) i_bit_i = 1'b0;
        // R4: ranking
        wr(1, 16'h7FFE);
        pulse((14'b1 << 2) | (14'b1 << 8));      // sources 3 and 9
        expect_out(1, 0, 3, "R4 order");
        // R2: write-one clear, zero no effect
        wr(0, 16'h0008);
        expect_out(1, 0, 5, "R2 clear3");
        wr(0, 16'h0000);
        chk_reg(0, 16'h0220, "R2 zero write");
        wr(0, 16'h0020);
        expect_out(1, 0, 9, "R2 clear5");
        // R5: promotion
        pulse(14'b1 << 1);                       // source 2
        expect_out(1, 0, 2, "R5 default");
        wr(3, 16'h0009);
        expect_out(1, 0, 9, "R5 promoted");
        wr(3, 16'h000F);
        expect_out(1, 0, 2, "R5 none");
        wr(3, 16'h0000);
        wr(0, 16'h7FFE);
        expect_out(0, 0, 0, "R2 all cleared");
        // R6: edge latched on external pin
        @(negedge clk) irq_n_i = 1'b0;
        repeat (3) @(negedge clk);
        irq_n_i = 1'b1;
        expect_out(1, 0, 0, "R6 latched");
        chk_reg(0, 16'h0001, "R6 flag0");
        wr(0, 16'h0001);
        expect_out(0, 0, 0, "R6 cleared");
        // R8: late option write ignored
        wr(2, 16'h0000);
        chk_reg(2, 16'h0001, "R8 late write");
        // R10: nonmaskable precedence, I bit set
        @(negedge clk) begin i_bit_i = 1'b1; nm_src_i = 4'b0100; end
        pulse(14'b1);                            // source 1 pending too
        expect_out(0, 1, 17, "R10 nm2");
        @(negedge clk) nm_src_i = 4'b0110;
        expect_out(0, 1, 16, "R10 nm1");
        @(negedge clk) begin nm_src_i = 4'b0000; i_bit_i = 1'b0; end
        expect_out(1, 0, 1, "R10 release");
        wr(0, 16'h0002);
        // R9: nonmaskable pin gated until X seen clear
        @(negedge clk) xirq_n_i = 1'b0;
        expect_out(0, 0, 0, "R9 gated");
        @(negedge clk) x_bit_i = 1'b0;
        @(negedge clk) x_bit_i = 1'b1;
        expect_out(0, 1, 19, "R9 enabled");
        @(negedge clk) xirq_n_i = 1'b1;
        expect_out(0, 0, 0, "R9 pin high");
        // second reset: R8 early write, R7 level mode, R9 re-gated
        do_reset();
        wr(2, 16'h0000);
        chk_reg(2, 16'h0000, "R8 early write");
        @(negedge clk) irq_n_i = 1'b0;
        expect_out(1, 0, 0, "R7 level low");
        @(negedge clk) irq_n_i = 1'b1;
        expect_out(0, 0, 0, "R7 level high");
        @(negedge clk) xirq_n_i = 1'b0;
        expect_out(0, 0, 0, "R9 after reset");
        @(negedge clk) xirq_n_i = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule